// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block sits beside a processor core and decides whether that core should be interrupted. It keeps three 256-entry bit vectors: the requests waiting to be taken, the vectors currently being serviced, and whether each request was level or edge triggered. It also keeps an 8-bit task priority. Each cycle it finds the highest pending request and the highest in-service vector. From the in-service vector and the task priority it forms a processor priority. The interrupt line to the core asserts only when the request's 16-vector priority class beats that processor priority.

The core takes an interrupt by pulsing an acknowledge request. One cycle later the block returns either the vector it moved from pending to in-service, or the configured spurious vector when nothing may be taken. An end-of-interrupt strobe retires the highest in-service vector. Software controls the block through a global enable level, a spurious vector value, and a 4-bit task priority write port.

Top module: `vipc_core`

## Requirements
- R1: While and right after a synchronous reset, the request, in-service and trigger vectors are empty, the task priority is 0, `irq` is low and `ack_done` is low.
- R2: A cycle with `set_valid` high marks `set_vector` as pending and records its trigger mode (1 for level, 0 for edge). A later accepted acknowledge of that vector reports this mode on `ack_level`.
- R3: `irq` is low whenever `sw_en` is low, whatever is pending.
- R4: With `sw_en` high, `irq` is high exactly when a request is pending and either the processor priority is 0 or bits 7:4 of the highest pending vector are strictly greater than bits 7:4 of the processor priority.
- R5: The processor priority equals the task priority when the task priority's bits 7:4 are at least bits 7:4 of the highest in-service vector (taken as 0 when none is in service). Otherwise it equals that in-service class in bits 7:4, with 0 in bits 3:0.
- R6: An acknowledge returns `spur_vec` and changes no state when `sw_en` is low, when no request is pending, or when the task priority is non-zero and the highest pending vector is less than or equal to it.
- R7: Any other acknowledge returns the highest pending vector, clears its pending bit and sets its in-service bit.
- R8: End-of-interrupt clears only the highest set in-service bit, and does nothing when none is set.
- R9: A task priority write stores `tpr_data` in bits 7:4 with 0 in bits 3:0. It takes effect from the following cycle.
- R10: Actions in the same cycle all see the state from before that cycle. A set of the vector being acknowledged leaves it pending. An acknowledge that puts a vector in service wins over an end-of-interrupt that clears the same vector.
- R11: `ack_done` is high for exactly the cycle after each cycle in which `ack_req` is high. `ack_vector` and `ack_level` are valid in that cycle, and `ack_level` is 0 for a spurious answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_valid | input | 1 | Raise a request this cycle |
| set_vector | input | 8 | Vector of the raised request |
| set_level | input | 1 | Trigger mode of the request: 1 level, 0 edge |
| ack_req | input | 1 | Core takes an interrupt |
| ack_done | output | 1 | Acknowledge answer valid |
| ack_vector | output | 8 | Vector handed to the core |
| ack_level | output | 1 | Trigger mode of the handed vector |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Task priority write |
| tpr_data | input | 4 | Task priority class to write |
| sw_en | input | 1 | Software enable |
| spur_vec | input | 8 | Vector returned on a spurious acknowledge |
| irq | output | 1 | Pending-interrupt line to the core |

## Verification
Acknowledge can coincide with a new request or with an end-of-interrupt. Both collisions decide which bit survives. Directed steps fire a set of the very vector being acknowledged, and an acknowledge together with an end-of-interrupt. A long random phase draws vectors from a narrow window so such overlaps recur often. A behavioural model applies the ordering of R10 and is compared on `irq` and on every acknowledge answer, every cycle.

// File: rtl/vipc_pkg.sv
package vipc_pkg;
  localparam int CLS_W = 4;
  typedef enum logic {ACK_SPURIOUS = 1'b0, ACK_TAKEN = 1'b1} ack_kind_e;
endpackage

// File: rtl/vipc_word_find.sv
module vipc_word_find #(
  parameter int WORD_W = 32,
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word,
  output logic              any,
  output logic [BIT_W-1:0]  idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int b = 0; b < WORD_W; b++) begin
      if (word[b]) begin
        any = 1'b1;
        idx = BIT_W'(b);
      end
    end
  end
endmodule

// File: rtl/vipc_prio_find.sv
module vipc_prio_find #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  localparam int IDX_W  = $clog2(NUM_VEC),
  localparam int NWORDS = NUM_VEC / WORD_W,
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic [NUM_VEC-1:0] vec,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  logic             w_any [NWORDS];
  logic [BIT_W-1:0] w_idx [NWORDS];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    vipc_word_find #(.WORD_W(WORD_W)) u_find (
      .word (vec[w*WORD_W +: WORD_W]),
      .any  (w_any[w]),
      .idx  (w_idx[w])
    );
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (w_any[w]) begin
        found = 1'b1;
        idx   = IDX_W'(w * WORD_W) | IDX_W'(w_idx[w]);
      end
    end
  end
endmodule

// File: rtl/vipc_core.sv
module vipc_core #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  localparam int IDX_W  = $clog2(NUM_VEC),
  localparam int CLS_W  = vipc_pkg::CLS_W,
  localparam int SUB_W  = IDX_W - CLS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_valid,
  input  logic [IDX_W-1:0] set_vector,
  input  logic             set_level,
  input  logic             ack_req,
  output logic             ack_done,
  output logic [IDX_W-1:0] ack_vector,
  output logic             ack_level,
  input  logic             eoi,
  input  logic             tpr_wr,
  input  logic [CLS_W-1:0] tpr_data,
  input  logic             sw_en,
  input  logic [IDX_W-1:0] spur_vec,
  output logic             irq
);
  import vipc_pkg::*;

  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;
  logic [IDX_W-1:0]   tpr_q;

  logic             irr_found, isr_found;
  logic [IDX_W-1:0] irr_hi, isr_hi;
  logic [CLS_W-1:0] isr_cls, tpr_cls, irr_cls, ppr_cls;
  logic [IDX_W-1:0] ppr;
  ack_kind_e        ack_kind;

  vipc_prio_find #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_irr_find (
    .vec (irr_q), .found (irr_found), .idx (irr_hi)
  );
  vipc_prio_find #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_isr_find (
    .vec (isr_q), .found (isr_found), .idx (isr_hi)
  );

  // Processor priority from task priority and in-service class
  always_comb begin
    isr_cls = isr_found ? isr_hi[IDX_W-1 -: CLS_W] : '0;
    tpr_cls = tpr_q[IDX_W-1 -: CLS_W];
    irr_cls = irr_hi[IDX_W-1 -: CLS_W];
    ppr     = (tpr_cls >= isr_cls) ? tpr_q : {isr_cls, {SUB_W{1'b0}}};
    ppr_cls = ppr[IDX_W-1 -: CLS_W];
  end

  assign irq = sw_en && irr_found && ((ppr == '0) || (irr_cls > ppr_cls));

  always_comb begin
    if (ack_req && sw_en && irr_found && !((tpr_q != '0) && (irr_hi <= tpr_q)))
      ack_kind = ACK_TAKEN;
    else
      ack_kind = ACK_SPURIOUS;
  end

  // Next-state: acknowledge clear, then set; eoi clear, then acknowledge set
  always_comb begin
    irr_n = irr_q;
    isr_n = isr_q;
    tmr_n = tmr_q;
    if (ack_kind == ACK_TAKEN) irr_n[irr_hi] = 1'b0;
    if (set_valid) begin
      irr_n[set_vector] = 1'b1;
      tmr_n[set_vector] = set_level;
    end
    if (eoi && isr_found) isr_n[isr_hi] = 1'b0;
    if (ack_kind == ACK_TAKEN) isr_n[irr_hi] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q      <= '0;
      isr_q      <= '0;
      tmr_q      <= '0;
      tpr_q      <= '0;
      ack_done   <= 1'b0;
      ack_vector <= '0;
      ack_level  <= 1'b0;
    end else begin
      irr_q    <= irr_n;
      isr_q    <= isr_n;
      tmr_q    <= tmr_n;
      ack_done <= ack_req;
      if (tpr_wr) tpr_q <= {tpr_data, {SUB_W{1'b0}}};
      if (ack_req) begin
        ack_vector <= (ack_kind == ACK_TAKEN) ? irr_hi : spur_vec;
        ack_level  <= (ack_kind == ACK_TAKEN) ? tmr_q[irr_hi] : 1'b0;
      end
    end
  end
endmodule

// File: rtl/vipc_core_chk.sv
module vipc_core_chk #(
  parameter int NUM_VEC = 256,
  localparam int IDX_W  = $clog2(NUM_VEC)
) (
  input logic               clk,
  input logic               rst,
  input logic               sw_en,
  input logic               irq,
  input logic               ack_req,
  input logic               ack_done,
  input logic [IDX_W-1:0]   ack_vector,
  input logic [IDX_W-1:0]   spur_vec,
  input logic               eoi,
  input logic [NUM_VEC-1:0] irr_q,
  input logic [NUM_VEC-1:0] isr_q
);
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !sw_en |-> !irq); // R3
  AST_IRQ_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    irq |-> (irr_q != '0)); // R4
  AST_ACK_LATENCY: assert property (@(posedge clk) disable iff (rst)
    ack_req |=> ack_done); // R11
  AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (rst)
    !ack_req |=> !ack_done); // R11
  AST_SPUR_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (ack_req && !sw_en) |=> (ack_vector == $past(spur_vec))); // R6
  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (rst)
    (eoi && (isr_q != '0) && !ack_req) |=>
      ($countones(isr_q) + 1 == $past($countones(isr_q)))); // R8
endmodule

bind vipc_core vipc_core_chk #(.NUM_VEC(NUM_VEC)) chk_i (
  .clk (clk), .rst (rst), .sw_en (sw_en), .irq (irq),
  .ack_req (ack_req), .ack_done (ack_done), .ack_vector (ack_vector),
  .spur_vec (spur_vec), .eoi (eoi), .irr_q (irr_q), .isr_q (isr_q)
);

// File: tb/vipc_core_tb_top.sv
`timescale 1ns/1ps
module vipc_core_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic set_valid = 0, set_level = 0, ack_req = 0, eoi = 0, tpr_wr = 0, sw_en = 0;
  logic [7:0] set_vector = 0, spur_vec = 8'hFF;
  logic [3:0] tpr_data = 0;
  logic ack_done, ack_level, irq;
  logic [7:0] ack_vector;

  int n_chk = 0, n_bad = 0;
  logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
  int m_tpr = 0;
  bit e_done = 0;
  int e_vec = 0;
  bit e_lvl = 0;

  always #2.5 clk = ~clk;

  vipc_core dut_i (
    .clk, .rst, .set_valid, .set_vector, .set_level, .ack_req, .ack_done,
    .ack_vector, .ack_level, .eoi, .tpr_wr, .tpr_data, .sw_en, .spur_vec, .irq
  );

  function automatic int top_bit(logic [255:0] v);
    int r = -1;
    for (int i = 0; i < 256; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic bit model_irq();
    int ih = top_bit(m_irr);
    int sh = top_bit(m_isr);
    int scls = (sh < 0) ? 0 : sh / 16;
    int ppr = ((m_tpr / 16) >= scls) ? m_tpr : scls * 16;
    if (!sw_en || ih < 0) return 0;
    return (ppr == 0) || ((ih / 16) > (ppr / 16));
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    check({tag, " irq R4"}, int'(irq), int'(model_irq()));
    check("R11 ack_done", int'(ack_done), int'(e_done));
    if (e_done) begin
      check({tag, " ack_vector R7"}, int'(ack_vector), e_vec);
      check({tag, " ack_level R2"}, int'(ack_level), int'(e_lvl));
    end
  endtask

  // Apply one cycle of stimulus at a falling edge, advance model, compare at next falling edge
  task automatic step(bit sv, int vec, bit lvl, bit ak, bit e, bit tw, int td, string tag);
    int ih = top_bit(m_irr);
    int sh = top_bit(m_isr);
    bit take = ak && sw_en && ih >= 0 && !(m_tpr != 0 && ih <= m_tpr);
    set_valid = sv; set_vector = 8'(vec); set_level = lvl;
    ack_req = ak; eoi = e; tpr_wr = tw; tpr_data = 4'(td);
    e_done = ak;
    if (ak) begin
      e_vec = take ? ih : int'(spur_vec);
      e_lvl = take ? m_tmr[ih] : 1'b0;
    end
    if (take) m_irr[ih] = 1'b0;
    if (sv) begin m_irr[vec] = 1'b1; m_tmr[vec] = lvl; end
    if (e && sh >= 0) m_isr[sh] = 1'b0;
    if (take) m_isr[ih] = 1'b1;
    if (tw) m_tpr = td * 16;
    @(posedge clk);
    @(negedge clk);
    set_valid = 0; ack_req = 0; eoi = 0; tpr_wr = 0;
    compare(tag);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 irq in reset", int'(irq), 0);
    check("R1 ack_done in reset", int'(ack_done), 0);
    rst = 0;
    @(negedge clk);
    compare("R1");
    // R3: disabled block stays quiet; R6: spurious answer
    step(1, 'h45, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 1, 0, 0, 0, "R6 disabled");
    sw_en = 1; #0.1;
    check("R4 enable raises irq", int'(irq), 1);
    step(0, 0, 0, 1, 0, 0, 0, "R7 take 45");
    step(1, 'h43, 1, 0, 0, 0, 0, "R5 same class blocked");
    step(1, 'h52, 0, 0, 0, 0, 0, "R4 higher class");
    step(0, 0, 0, 1, 0, 0, 0, "R7 take 52");
    step(0, 0, 0, 0, 1, 0, 0, "R8 retire 52");
    step(0, 0, 0, 0, 1, 0, 0, "R8 retire 45");
    step(0, 0, 0, 0, 1, 0, 0, "R8 none in service");
    step(0, 0, 0, 0, 0, 1, 5, "R9 tpr 50");
    step(0, 0, 0, 1, 0, 0, 0, "R6 below tpr");
    step(0, 0, 0, 0, 0, 1, 4, "R9 tpr 40");
    step(0, 0, 0, 1, 0, 0, 0, "R7 above tpr same class");
    step(0, 0, 0, 0, 0, 1, 0, "R9 tpr 0");
    step(1, 'h60, 1, 0, 0, 0, 0, "R2 level");
    step(1, 'h60, 1, 1, 0, 0, 0, "R10 set and take same vector");
    step(0, 0, 0, 1, 1, 0, 0, "R10 take with eoi");
    step(0, 0, 0, 1, 0, 0, 0, "R6 empty");
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) begin sw_en = ($urandom % 4) != 0; spur_vec = 8'($urandom); end
      step(($urandom % 3) == 0, 'h30 + ($urandom % 48), 1'($urandom),
           ($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 40) == 0,
           int'($urandom % 8), "R10 random");
    end
    finish_run();
  end
endmodule